// File: doc/BRIEF.md
# Buffered Serial Transmitter with Level Interrupt

This block is the sending side of a classic asynchronous serial adapter. A processor writes bytes into a one-byte holding register through a small register port. From there each byte is handed to a shift register, which sends it on a single line as a start bit, eight data bits (least significant first) and a stop bit. Each bit lasts a fixed number of ticks of an external 16x oversampling strobe. Because the holding register can accept the next byte while the current one is still being shifted, a processor that keeps it topped up gets frames with no idle time between them.

The processor learns what it can do through a status register and an active-low, level-sensitive interrupt line. The status register has separate bits for "holding register empty" and "receive data full". It also has a summary bit that is set while an interrupt is pending. The receive-full condition arrives from outside as a plain input. It is shown in the status register, and its rising edge also raises the interrupt. After every hand-off from the holding register to the shifter, the empty flag is held back until the next oversampling tick, which is one sixteenth of a bit time. Only then does it rise and raise the interrupt. Any status read clears the pending interrupt, even while the empty condition is still true.

The register port has no back-pressure. A data write is always accepted. A write while the holding register is full replaces the byte waiting there. Software is expected to test the empty bit before it writes. Read data is a combinational view of the addressed register. Only a read strobe on the status address has a side effect.

Top module: `uart_tx_irq`

## Requirements
- R1: After reset the line output is high, the interrupt output is high, and the status register reads 0x10. Status layout: bit 7 is interrupt pending, bit 4 is holding register empty, bit 3 is receive full, and all other bits read 0.
- R2: Each byte is sent as one low start bit, then eight data bits least significant first, then one high stop bit. Every bit lasts 16 oversampling ticks, and the line rests high between frames.
- R3: A data write (address 0) while the shifter is idle moves the byte into the shifter on the next clock. Status bit 4 reads 0 until the first oversampling tick after that transfer. Bit 4 then reads 1, and the interrupt output goes low one clock later.
- R4: A data write while a frame is being shifted keeps status bit 4 at 0 and raises no interrupt until that byte is transferred. The next frame's start bit follows the previous stop bit with no idle time.
- R5: Once low, the interrupt output stays low until a status read.
- R6: A status read (select with write low, address 1) clears the pending interrupt and bit 7 on the next clock, while bit 4 stays 1. No further interrupt comes from that empty condition.
- R7: The receive-full input is shown in status bit 3. Its rising edge drives the interrupt output low on the next clock. A level held high does not raise it again after a clear.
- R8: A status read in the same clock as a new interrupt event leaves the interrupt pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-clock strobe at 16 times the bit rate |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = transmit data, 1 = status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Addressed register (status, or 0 for the data address) |
| rx_full_in | input | 1 | Receive-data-full flag from the receiver |
| txd | output | 1 | Serial line, idles high |
| irq_n | output | 1 | Active-low level interrupt |

## Verification
The bench writes a single byte to an idle transmitter and then waits for exactly one interrupt, one tick after the hand-off. A design that signals empty at once would interrupt early, and a design that rearms after the clear would interrupt twice. The bench also writes a second byte while the first is still shifting. It checks that no interrupt appears before that byte moves into the shifter, and that the two start bits are exactly one frame apart; a one-clock gap between frames would show up as a timing mismatch. The bench further checks a status read that lands on the same clock as a receive-full edge, where a design that lets the clear win would lose the event. A scoreboard decodes every frame and compares it with the bytes written, including all-zero and all-one patterns.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  // Status register bit positions (software decodes these)
  localparam int STAT_IRQ_BIT = 7;
  localparam int STAT_TXE_BIT = 4;
  localparam int STAT_RXF_BIT = 3;

  // Register addresses
  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  typedef enum logic [0:0] {SH_IDLE = 1'b0, SH_RUN = 1'b1} sh_state_e;
endpackage

// File: rtl/uart_tx_hold.sv
// Holding register plus the delayed re-arm of the empty flag.
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              baud_tick,
  input  logic              shift_ready,
  output logic              load,
  output logic [DATA_W-1:0] load_byte,
  output logic              tx_empty
);
  logic              hold_full;
  logic [DATA_W-1:0] hold_byte;
  logic              rearm_wait;

  // hand-off: a full holding register meets a shifter that can take it
  assign load      = hold_full && shift_ready;
  assign load_byte = hold_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_byte <= '0;
    end else if (wr_en) begin
      // a write wins over a same-cycle hand-off: the new byte stays held
      hold_full <= 1'b1;
      hold_byte <= wr_byte;
    end else if (load) begin
      hold_full <= 1'b0;
    end
  end

  // empty flag is withheld until the first oversampling tick after a hand-off
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rearm_wait <= 1'b0;
    else if (load)
      rearm_wait <= 1'b1;
    else if (baud_tick)
      rearm_wait <= 1'b0;
  end

  assign tx_empty = !hold_full && !rearm_wait;
endmodule

// File: rtl/uart_tx_shift.sv
// Frame serializer: start, DATA_W bits LSB first, stop; OVS ticks per bit.
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_byte,
  output logic              ready,
  output logic              busy,
  output logic              txd
);
  localparam int FRAME_BITS = DATA_W + 2;
  localparam int TW         = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int BW         = $clog2(FRAME_BITS + 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(OVS - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(FRAME_BITS - 1);

  sh_state_e             state;
  logic [FRAME_BITS-1:0] shreg;
  logic [TW-1:0]         tcnt;
  logic [BW-1:0]         bcnt;
  logic                  bit_done;
  logic                  frame_done;

  assign bit_done   = (state == SH_RUN) && baud_tick && (tcnt == TICK_LAST);
  assign frame_done = bit_done && (bcnt == BIT_LAST);
  // accepting on the last tick of the stop bit gives gap-free frames
  assign ready      = (state == SH_IDLE) || frame_done;
  assign busy       = (state == SH_RUN);
  assign txd        = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SH_IDLE;
      shreg <= '1;
      tcnt  <= '0;
      bcnt  <= '0;
    end else if (load) begin
      state <= SH_RUN;
      shreg <= {1'b1, load_byte, 1'b0};
      tcnt  <= '0;
      bcnt  <= '0;
    end else if (busy && baud_tick) begin
      if (tcnt == TICK_LAST) begin
        tcnt <= '0;
        if (bcnt == BIT_LAST) begin
          state <= SH_IDLE;
        end else begin
          bcnt  <= bcnt + 1'b1;
          shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
        end
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_tx_irqstat.sv
// Edge-detected interrupt latch and status register assembly.
module uart_tx_irqstat
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_empty,
  input  logic       rx_full,
  input  logic       rd_stat,
  output logic       set_evt,
  output logic       irq_pend,
  output logic [7:0] status
);
  logic tx_empty_q;
  logic rx_full_q;
  logic tx_rise;
  logic rx_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_empty_q <= 1'b1;   // empty at reset is not an event
      rx_full_q  <= 1'b0;
    end else begin
      tx_empty_q <= tx_empty;
      rx_full_q  <= rx_full;
    end
  end

  assign tx_rise = tx_empty && !tx_empty_q;
  assign rx_rise = rx_full && !rx_full_q;
  assign set_evt = tx_rise || rx_rise;

  // a new event outranks a coincident clear so nothing is dropped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      irq_pend <= 1'b0;
    else if (set_evt)
      irq_pend <= 1'b1;
    else if (rd_stat)
      irq_pend <= 1'b0;
  end

  always_comb begin
    status               = '0;
    status[STAT_IRQ_BIT] = irq_pend;
    status[STAT_TXE_BIT] = tx_empty;
    status[STAT_RXF_BIT] = rx_full;
  end
endmodule

// File: rtl/uart_tx_irq.sv
module uart_tx_irq
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              rx_full_in,
  output logic              txd,
  output logic              irq_n
);
  logic              wr_data;
  logic              rd_stat;
  logic              load;
  logic [DATA_W-1:0] load_byte;
  logic              shift_ready;
  logic              shift_busy;
  logic              tx_empty;
  logic              set_evt;
  logic              irq_pend;
  logic [7:0]        status;

  assign wr_data = bus_sel &&  bus_wr && (bus_addr == ADDR_DATA);
  assign rd_stat = bus_sel && !bus_wr && (bus_addr == ADDR_STAT);

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_data),
    .wr_byte     (bus_wdata),
    .baud_tick   (baud_tick),
    .shift_ready (shift_ready),
    .load        (load),
    .load_byte   (load_byte),
    .tx_empty    (tx_empty)
  );

  uart_tx_shift #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .load      (load),
    .load_byte (load_byte),
    .ready     (shift_ready),
    .busy      (shift_busy),
    .txd       (txd)
  );

  uart_tx_irqstat u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_empty (tx_empty),
    .rx_full  (rx_full_in),
    .rd_stat  (rd_stat),
    .set_evt  (set_evt),
    .irq_pend (irq_pend),
    .status   (status)
  );

  assign irq_n     = !irq_pend;
  assign bus_rdata = (bus_addr == ADDR_STAT) ? status : 8'h00;
endmodule

// File: rtl/uart_tx_irq_chk.sv
module uart_tx_irq_chk (
  input logic clk,
  input logic rst_n,
  input logic txd,
  input logic irq_n,
  input logic rd_stat,
  input logic wr_data,
  input logic set_evt,
  input logic load,
  input logic tx_empty,
  input logic shift_busy,
  input logic rx_full_in
);
  p_line_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_busy |-> txd);

  p_no_empty_after_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !tx_empty);

  p_write_holds_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> !tx_empty);

  p_level_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !rd_stat) |=> !irq_n);

  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !set_evt) |=> irq_n);

  p_rx_raises_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full_in) |=> !irq_n);

  p_no_lost_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && set_evt) |=> !irq_n);
endmodule

bind uart_tx_irq uart_tx_irq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .txd        (txd),
  .irq_n      (irq_n),
  .rd_stat    (rd_stat),
  .wr_data    (wr_data),
  .set_evt    (set_evt),
  .load       (load),
  .tx_empty   (tx_empty),
  .shift_busy (shift_busy),
  .rx_full_in (rx_full_in)
);

// File: tb/test_uart_tx_irq.sv
`timescale 1ns/1ps
module test_uart_tx_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_addr = 1'b1;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       rx_full_in = 1'b0;
  logic       txd;
  logic       irq_n;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  longint cyc = 0;
  longint last_start = 0;
  longint prev_start = 0;
  logic [7:0] expq[$];
  logic [1:0] tdiv = 2'd0;

  always #4 clk = ~clk;   // 125 MHz

  // oversampling strobe every 4 clocks -> 64 clocks per bit, 640 per frame
  always @(posedge clk) begin
    cyc       <= cyc + 1;
    tdiv      <= tdiv + 2'd1;
    baud_tick <= (tdiv == 2'd3);
  end

  uart_tx_irq i_uart_tx_irq (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_full_in(rx_full_in), .txd(txd), .irq_n(irq_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // driver: push expected byte, then write it to the data register
  task automatic write_byte(input logic [7:0] d);
    expq.push_back(d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 1'b1;
  endtask

  task automatic read_status();
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wait_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      while (!baud_tick) @(negedge clk);
    end
  endtask

  // monitor: decode frames at mid-bit and compare with the scoreboard
  initial begin
    logic [7:0] got;
    logic [7:0] want;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      while (txd !== 1'b0) @(negedge clk);
      prev_start = last_start;
      last_start = cyc;
      wait_ticks(8);
      chk(txd == 1'b0, "R2", "start bit low", txd, 0);
      for (int b = 0; b < 8; b++) begin
        wait_ticks(16);
        got[b] = txd;
      end
      wait_ticks(16);
      chk(txd == 1'b1, "R2", "stop bit high", txd, 1);
      if (expq.size() == 0) begin
        chk(1'b0, "R2", "unexpected frame", got, 0);
      end else begin
        want = expq.pop_front();
        chk(got == want, "R2", "frame data", got, want);
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit ok;
    int n;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1", "txd after reset", txd, 1);
    chk(irq_n == 1'b1, "R1", "irq_n after reset", irq_n, 1);
    chk(bus_rdata == 8'h10, "R1", "status after reset", bus_rdata, 8'h10);

    // R3 single write to idle shifter
    write_byte(8'hA5);
    chk(bus_rdata[4] == 1'b0, "R3", "empty bit right after write", bus_rdata, 0);
    @(negedge clk);   // transfer done on this edge
    ok = 1'b1;
    n = 0;
    while (!baud_tick) begin
      if (bus_rdata[4] || !irq_n) ok = 1'b0;
      @(negedge clk);
      n++;
    end
    if (bus_rdata[4] || !irq_n) ok = 1'b0;
    chk(ok, "R3", "empty/irq held before first tick", bus_rdata, 0);
    @(negedge clk);
    chk(bus_rdata[4] == 1'b1, "R3", "empty bit after tick", bus_rdata[4], 1);
    chk(irq_n == 1'b1, "R3", "irq not yet low", irq_n, 1);
    @(negedge clk);
    chk(irq_n == 1'b0, "R3", "irq low one clock after empty", irq_n, 0);
    chk(bus_rdata == 8'h90, "R3", "status with pending", bus_rdata, 8'h90);

    // R5 level held
    repeat (30) @(negedge clk);
    chk(irq_n == 1'b0, "R5", "irq still low", irq_n, 0);

    // R6 read clears; single interrupt only
    read_status();
    chk(irq_n == 1'b1, "R6", "irq released by read", irq_n, 1);
    chk(bus_rdata == 8'h10, "R6", "status after read", bus_rdata, 8'h10);
    ok = 1'b1;
    for (int k = 0; k < 800; k++) begin
      @(negedge clk);
      if (!irq_n) ok = 1'b0;
    end
    chk(ok, "R6", "no second interrupt", irq_n, 1);
    chk(expq.size() == 0, "R2", "first frame consumed", expq.size(), 0);

    // R4 write during shifting
    write_byte(8'h3C);
    repeat (20) @(negedge clk);
    read_status();
    write_byte(8'hC3);
    ok = 1'b1;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (!irq_n || bus_rdata[4]) ok = 1'b0;
    end
    chk(ok, "R4", "held byte keeps empty low, no irq", bus_rdata, 0);
    n = 0;
    while (irq_n && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(irq_n == 1'b0, "R4", "irq after held byte transfers", irq_n, 0);
    read_status();
    repeat (1400) @(negedge clk);
    chk(last_start - prev_start == 640, "R4", "gap-free frame spacing",
        int'(last_start - prev_start), 640);

    // R2 stream of boundary patterns, polling the empty bit
    begin
      logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'h01, 8'h80};
      for (int p = 0; p < 4; p++) begin
        while (!bus_rdata[4]) @(negedge clk);
        write_byte(pats[p]);
      end
    end
    repeat (3000) @(negedge clk);
    chk(expq.size() == 0, "R2", "all frames received", expq.size(), 0);
    read_status();

    // R7 receive-full edge
    @(negedge clk);
    rx_full_in = 1'b1;
    @(negedge clk);
    chk(bus_rdata[3] == 1'b1, "R7", "receive bit shown", bus_rdata[3], 1);
    chk(irq_n == 1'b0, "R7", "irq from receive edge", irq_n, 0);
    read_status();
    repeat (20) @(negedge clk);
    chk(irq_n == 1'b1, "R7", "held level no retrigger", irq_n, 1);
    rx_full_in = 1'b0;
    repeat (3) @(negedge clk);

    // R8 read on same clock as new event
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 1'b1;
    rx_full_in = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0;
    chk(irq_n == 1'b0, "R8", "coincident read keeps pending", irq_n, 0);
    read_status();
    chk(irq_n == 1'b1, "R8", "later read clears", irq_n, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule